// File: doc/BRIEF.md
# Card Presence Interrupt Logic

This block watches the card-detect and write-protect levels of a removable storage card slot and turns them into the present-state flags and normal interrupt status bits that an SD host controller reports. Both levels arrive asynchronously. Each passes through a two-flop synchroniser. A rising edge of the synchronised presence level is an insertion and a falling edge is a removal. Each event is latched as a status bit only when software has enabled that bit. Error events from elsewhere in the controller are latched into a small error status vector under their own enable mask. A summary bit in the normal status word reflects whether any enabled error bit is set.

Software reaches the block through a simple write port: one address selects the normal status word (write one to clear), the normal status enable, the normal signal enable, the error status vector (write one to clear) and the error status enable. The interrupt request is the masked OR of the normal status word. A software reset-all pulse clears every register. A power-on reset does the same and, when the quirk parameter is set, also arms a one-shot flag. That flag makes an insertion interrupt appear the first time software enables it, as if the card had been inserted while the interrupt was still disabled.

Top module: `card_presence_irq`

## Requirements
- R1: `card_present_o` equals `card_in_i` delayed by two clock edges. `wr_prot_o` is the inverse of `card_ro_i` after the same delay, so it is 1 when the card is writable.
- R2: A 0-to-1 change of the synchronised presence level sets normal status bit 0 (insert) only when normal status enable bit 0 is 1. The enable is written at address 1.
- R3: A 1-to-0 change of the synchronised presence level sets normal status bit 1 (remove) only when normal status enable bit 1 is 1.
- R4: A write to address 0 clears each normal status bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: An `err_evt_i` pulse sets error status bit i only when error status enable bit i (address 4) is 1. A write to address 3 clears the error status bits whose data bit is 1.
- R6: Normal status bit 15 (error summary) is 1 exactly when some error status bit is set and also enabled. Clearing the enable drops the summary even though the error bit stays set.
- R7: `irq_o` is 1 exactly when some normal status bit is 1 and its bit in the signal enable (address 2) is also 1.
- R8: One cycle of `sw_reset_all_i` clears all status and enable registers. A card that stays inserted across this reset does not raise a new insert event afterwards.
- R9: With `PEND_QUIRK`=1, a power-on reset arms a flag. The first write to address 1 with data bit 0 set then sets insert status at once and disarms the flag. Later such writes do not set the bit again.
- R10: A software reset disarms the flag of R9. A software reset never arms it.
- R11: With `PEND_QUIRK`=0, writing the insert enable after power-on does not set insert status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| card_in_i | input | 1 | Asynchronous card-inserted level |
| card_ro_i | input | 1 | Asynchronous card read-only level |
| sw_reset_all_i | input | 1 | Software reset-all pulse |
| err_evt_i | input | NERR | Error event pulses |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select (0..4) |
| wr_data_i | input | 16 | Register write data |
| card_present_o | output | 1 | Synchronised presence flag |
| wr_prot_o | output | 1 | Write-allowed flag (inverse of read-only) |
| nsts_o | output | 16 | Normal status: bit 0 insert, bit 1 remove, bit 15 error summary |
| ests_o | output | NERR | Error status |
| irq_o | output | 1 | Interrupt request |

## Verification
The checks assume that the card levels stay still for at least three clock edges around each change. They also assume that a write to the enable register does not land in the same cycle as a presence edge. The bench changes a level only at a falling clock edge and then waits four cycles before it touches any register. The assertions also assume that a write strobe lasts exactly one cycle. The bench's write and pulse tasks hold each strobe for one full clock period.

// File: rtl/cpi_pkg.sv
package cpi_pkg;
  localparam int STS_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int B_INS   = 0;
  localparam int B_RMV   = 1;
  localparam int B_ERRS  = STS_W - 1;

  typedef enum logic [ADDR_W-1:0] {
    A_NSTS    = 3'd0,
    A_NSTS_EN = 3'd1,
    A_NSIG_EN = 3'd2,
    A_ESTS    = 3'd3,
    A_ESTS_EN = 3'd4
  } cpi_addr_e;
endpackage

// File: rtl/cpi_sync.sv
module cpi_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  for (genvar g = 0; g < W; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= d_i[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/cpi_edge.sv
module cpi_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/cpi_stsreg.sv
module cpi_stsreg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_all_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] w1c_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sts_q;
  logic [W-1:0] sts_d;
  logic         sts_en;

  always_comb begin
    sts_en = clr_all_i | (|set_i) | (|w1c_i);
    if (clr_all_i) sts_d = '0;
    else           sts_d = (sts_q & ~w1c_i) | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  assign q_o = sts_q;
endmodule

// File: rtl/card_presence_irq.sv
module card_presence_irq
  import cpi_pkg::*;
#(
  parameter int NERR       = 4,
  parameter bit PEND_QUIRK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_in_i,
  input  logic              card_ro_i,
  input  logic              sw_reset_all_i,
  input  logic [NERR-1:0]   err_evt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [STS_W-1:0]  wr_data_i,
  output logic              card_present_o,
  output logic              wr_prot_o,
  output logic [STS_W-1:0]  nsts_o,
  output logic [NERR-1:0]   ests_o,
  output logic              irq_o
);
  localparam int NEV = 2;

  logic [1:0]       lvl_sync;
  logic             ins_evt, rmv_evt;
  logic             hit_nsts, hit_nsts_en, hit_nsig, hit_ests, hit_ests_en;
  logic             quirk_fire;
  logic [NEV-1:0]   nsts_set, nsts_w1c, nsts_q;
  logic [NERR-1:0]  ests_set, ests_w1c, ests_q;
  logic [NEV-1:0]   nsts_en_q, nsts_en_d;
  logic [STS_W-1:0] nsig_q, nsig_d;
  logic [NERR-1:0]  ests_en_q, ests_en_d;
  logic             pend_q, pend_d;
  logic             en_nsts_en, en_nsig, en_ests_en, en_pend;

  cpi_sync #(.W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({card_ro_i, card_in_i}),
    .q_o   (lvl_sync)
  );

  cpi_edge #(.W(1)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl_sync[0]),
    .rise_o (ins_evt),
    .fall_o (rmv_evt)
  );

  always_comb begin
    hit_nsts    = wr_en_i && (wr_addr_i == A_NSTS);
    hit_nsts_en = wr_en_i && (wr_addr_i == A_NSTS_EN);
    hit_nsig    = wr_en_i && (wr_addr_i == A_NSIG_EN);
    hit_ests    = wr_en_i && (wr_addr_i == A_ESTS);
    hit_ests_en = wr_en_i && (wr_addr_i == A_ESTS_EN);
    quirk_fire  = pend_q && hit_nsts_en && wr_data_i[B_INS];
  end

  always_comb begin
    nsts_set        = '0;
    nsts_set[B_INS] = (ins_evt && nsts_en_q[B_INS]) || quirk_fire;
    nsts_set[B_RMV] = rmv_evt && nsts_en_q[B_RMV];
    nsts_w1c        = hit_nsts ? wr_data_i[NEV-1:0] : '0;
    ests_set        = err_evt_i & ests_en_q;
    ests_w1c        = hit_ests ? wr_data_i[NERR-1:0] : '0;
  end

  cpi_stsreg #(.W(NEV)) u_nsts (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (sw_reset_all_i),
    .set_i     (nsts_set),
    .w1c_i     (nsts_w1c),
    .q_o       (nsts_q)
  );

  cpi_stsreg #(.W(NERR)) u_ests (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all_i (sw_reset_all_i),
    .set_i     (ests_set),
    .w1c_i     (ests_w1c),
    .q_o       (ests_q)
  );

  // next-state for the enable registers and the pending flag
  always_comb begin
    en_nsts_en = sw_reset_all_i | hit_nsts_en;
    en_nsig    = sw_reset_all_i | hit_nsig;
    en_ests_en = sw_reset_all_i | hit_ests_en;
    en_pend    = sw_reset_all_i | quirk_fire;
    nsts_en_d  = sw_reset_all_i ? '0 : wr_data_i[NEV-1:0];
    nsig_d     = sw_reset_all_i ? '0 : wr_data_i;
    ests_en_d  = sw_reset_all_i ? '0 : wr_data_i[NERR-1:0];
    pend_d     = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nsts_en_q <= '0;
      nsig_q    <= '0;
      ests_en_q <= '0;
      pend_q    <= PEND_QUIRK;
    end else begin
      if (en_nsts_en) nsts_en_q <= nsts_en_d;
      if (en_nsig)    nsig_q    <= nsig_d;
      if (en_ests_en) ests_en_q <= ests_en_d;
      if (en_pend)    pend_q    <= pend_d;
    end
  end

  always_comb begin
    nsts_o         = '0;
    nsts_o[B_INS]  = nsts_q[B_INS];
    nsts_o[B_RMV]  = nsts_q[B_RMV];
    nsts_o[B_ERRS] = |(ests_q & ests_en_q);
  end

  assign ests_o         = ests_q;
  assign irq_o          = |(nsts_o & nsig_q);
  assign card_present_o = lvl_sync[0];
  assign wr_prot_o      = ~lvl_sync[1];
endmodule

// File: rtl/cpi_checker.sv
module cpi_checker
  import cpi_pkg::*;
#(
  parameter int NERR = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              card_in_i,
  input logic              sw_reset_all_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [STS_W-1:0]  wr_data_i,
  input logic              card_present_o,
  input logic [STS_W-1:0]  nsts_o,
  input logic [NERR-1:0]   ests_o,
  input logic              irq_o,
  input logic [1:0]        nsts_en_q,
  input logic [STS_W-1:0]  nsig_q,
  input logic              pend_q
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  AST_PRESENT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> (card_present_o == $past(card_in_i, 2))); // R1

  AST_INS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nsts_o[B_INS]) |-> ($past(nsts_en_q[B_INS]) ||
      $past(wr_en_i && (wr_addr_i == A_NSTS_EN) && wr_data_i[B_INS]))); // R2

  AST_RMV_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nsts_o[B_RMV]) |-> $past(nsts_en_q[B_RMV])); // R3

  AST_SUM_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    nsts_o[B_ERRS] |-> (ests_o != '0)); // R6

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (nsig_q == '0) |-> !irq_o); // R7

  AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_all_i |=> ((nsts_o == '0) && (ests_o == '0) && !pend_q)); // R8

  AST_PEND_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> ($past(sw_reset_all_i) || nsts_o[B_INS])); // R9

  AST_PEND_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(pend_q)); // R10
endmodule

bind card_presence_irq cpi_checker #(.NERR(NERR)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .card_in_i      (card_in_i),
  .sw_reset_all_i (sw_reset_all_i),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .wr_data_i      (wr_data_i),
  .card_present_o (card_present_o),
  .nsts_o         (nsts_o),
  .ests_o         (ests_o),
  .irq_o          (irq_o),
  .nsts_en_q      (nsts_en_q),
  .nsig_q         (nsig_q),
  .pend_q         (pend_q)
);

// File: tb/card_presence_irq_bench.sv
module card_presence_irq_bench;
  localparam int NERR = 4;

  logic        clk;
  logic        rst_n;
  logic        card_in, card_ro, sw_rst;
  logic [NERR-1:0] err_evt;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;

  logic        pres_q, wp_q, irq_q;
  logic [15:0] nsts_q;
  logic [NERR-1:0] ests_q;
  logic        pres_n, wp_n, irq_n;
  logic [15:0] nsts_n;
  logic [NERR-1:0] ests_n;

  int checks = 0;
  int fails  = 0;

  card_presence_irq #(.NERR(NERR), .PEND_QUIRK(1'b1)) u_card_presence_irq (
    .clk(clk), .rst_n(rst_n), .card_in_i(card_in), .card_ro_i(card_ro),
    .sw_reset_all_i(sw_rst), .err_evt_i(err_evt), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .card_present_o(pres_q),
    .wr_prot_o(wp_q), .nsts_o(nsts_q), .ests_o(ests_q), .irq_o(irq_q));

  card_presence_irq #(.NERR(NERR), .PEND_QUIRK(1'b0)) u_card_presence_irq_nq (
    .clk(clk), .rst_n(rst_n), .card_in_i(card_in), .card_ro_i(card_ro),
    .sw_reset_all_i(sw_rst), .err_evt_i(err_evt), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .card_present_o(pres_n),
    .wr_prot_o(wp_n), .nsts_o(nsts_n), .ests_o(ests_n), .irq_o(irq_n));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_err(input logic [NERR-1:0] e);
    @(negedge clk); err_evt = e;
    @(negedge clk); err_evt = '0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_rst = 1'b1;
    @(negedge clk); sw_rst = 1'b0;
  endtask

  task automatic power_on();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; card_in = 1'b0; card_ro = 1'b0; sw_rst = 1'b0;
    err_evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    power_on();
    settle();
    check("R1 reset present", pres_q, 0);
    check("R1 reset wr_prot", wp_q, 1);
    check("R8 reset nsts", nsts_q, 0);
    check("R7 reset irq", irq_q, 0);

    // power-on pending insert
    wr(3'd1, 16'h0001);
    check("R9 quirk fires", nsts_q, 16'h0001);
    check("R11 no quirk", nsts_n, 16'h0000);
    wr(3'd0, 16'h0001);
    check("R4 w1c insert", nsts_q, 16'h0000);
    wr(3'd1, 16'h0000);
    wr(3'd1, 16'h0001);
    check("R9 fires once", nsts_q, 16'h0000);

    // sweep insert/remove enables
    for (int en = 0; en < 4; en++) begin
      wr(3'd1, 16'(en));
      wr(3'd0, 16'h0003);
      card_in = 1'b1; settle();
      check("R1 present high", pres_q, 1);
      check("R2 insert", nsts_q, 32'(en & 1));
      check("R2 insert nq", nsts_n, 32'(en & 1));
      wr(3'd0, 16'h0003);
      card_in = 1'b0; settle();
      check("R1 present low", pres_q, 0);
      check("R3 remove", nsts_q, 32'(en & 2));
      wr(3'd0, 16'h0003);
    end

    // write-one-to-clear selectivity
    wr(3'd1, 16'h0001);
    card_in = 1'b1; settle();
    wr(3'd0, 16'h0000);
    check("R4 zero keeps", nsts_q, 16'h0001);
    wr(3'd0, 16'h0002);
    check("R4 other bit keeps", nsts_q, 16'h0001);
    wr(3'd0, 16'h0001);
    check("R4 one clears", nsts_q, 16'h0000);
    card_in = 1'b0; settle();
    check("R3 remove disabled", nsts_q, 16'h0000);

    // write protect
    card_ro = 1'b1; settle();
    check("R1 ro -> wp low", wp_q, 0);
    card_ro = 1'b0; settle();
    check("R1 rw -> wp high", wp_q, 1);

    // error enable sweep
    for (int e = 0; e < 16; e++) begin
      wr(3'd4, 16'(e));
      pulse_err(4'hF);
      check("R5 err set", ests_q, 32'(e));
      check("R6 summary", nsts_q[15], (e != 0) ? 1 : 0);
      wr(3'd3, 16'h000F);
      check("R5 err w1c", ests_q, 0);
      check("R6 summary clear", nsts_q[15], 0);
    end
    wr(3'd4, 16'h000F);
    pulse_err(4'b0101);
    check("R5 partial set", ests_q, 4'b0101);
    wr(3'd4, 16'h0000);
    check("R6 summary masked", nsts_q[15], 0);
    check("R6 err kept", ests_q, 4'b0101);
    wr(3'd3, 16'h0001);
    check("R5 partial w1c", ests_q, 4'b0100);
    wr(3'd3, 16'h000F);

    // interrupt signal enable sweep
    wr(3'd4, 16'h000F);
    pulse_err(4'b0001);
    wr(3'd1, 16'h0001);
    card_in = 1'b1; settle();
    check("R2 status for irq", nsts_q, 16'h8001);
    for (int s = 0; s < 8; s++) begin
      wr(3'd2, (s & 4) ? (16'h8000 | 16'(s & 3)) : 16'(s & 3));
      check("R7 irq", irq_q, ((s & 1) != 0 || (s & 4) != 0) ? 1 : 0);
      check("R7 irq nq", irq_n, ((s & 1) != 0 || (s & 4) != 0) ? 1 : 0);
    end

    // software reset with card held inserted
    pulse_sw();
    check("R8 nsts cleared", nsts_q, 0);
    check("R8 ests cleared", ests_q, 0);
    check("R8 irq cleared", irq_q, 0);
    settle();
    check("R8 no spurious event", nsts_q, 0);
    wr(3'd1, 16'h0001);
    check("R8 enable cleared, no event", nsts_q, 0);

    // software reset disarms pending flag
    card_in = 1'b0; settle();
    wr(3'd1, 16'h0000);
    power_on();
    pulse_sw();
    wr(3'd1, 16'h0001);
    check("R10 sw reset disarms", nsts_q, 0);
    power_on();
    wr(3'd1, 16'h0001);
    check("R9 re-armed by power-on", nsts_q, 16'h0001);
    check("R11 still no quirk", nsts_n, 16'h0000);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule